// File: doc/BRIEF.md
# Leakage-aware ALU power-gating controller

This controller decides, once per fixed evaluation window, how many of a group of ALUs stay powered and which of them are switched off. On every cycle it receives the number of instructions that are ready to issue. That count is clipped to the issue width. One value in every stride of cycles is added into a window accumulator. When the window closes, the total is compared against a set of programmable thresholds. The result is the number of ALUs to keep on: one, plus one more for each threshold the total reaches.

The ALUs that are not needed are chosen by their digital leakage-sensor codes. The leakiest units are switched off first. The resulting per-ALU gate mask and the window total are registered at the window boundary. They are then held unchanged for the whole of the next window. The power switches, the sensors and the ALUs themselves are outside this block. Its only outputs are the mask and the last window total.

Top module: `alu_gate_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `gate_off` to all zeros, so every ALU is powered. It also clears `win_sum` to zero, restarts the window at cycle 0 and reloads the thresholds with 133, 233 and 333.
- R2: A ready count above the issue width (4) is treated as 4, so `ready_cnt` values 5 to 63 add 4 to the window total.
- R3: The window is 512 cycles long. Cycle 0 is the first edge after reset is released. Only cycles whose index modulo 4 equals 3 add the clipped count, giving 128 samples. The count on every other cycle is ignored. The total therefore ranges from 0 to 512.
- R4: At the edge of cycle 511, `win_sum` takes the window total, and that value is held for the entire next window. The accumulator restarts from zero for the following window.
- R5: The number of powered ALUs equals 1 plus the number of thresholds that the window total meets or exceeds. The count of set bits in `gate_off` is 4 minus that number.
- R6: Writing with `thr_wr_en` high and `thr_wr_idx` of 0, 1 or 2 replaces that threshold with `thr_wr_data` from the next cycle onward. A write with index 3 changes nothing.
- R7: Each ALU's 3-bit leakage code sits in `leak_code` bits [3i+2:3i], where i is the ALU index. The codes are sampled at the window-closing edge. The ALUs switched off are those with the highest codes. When two codes are equal, the higher-index ALU is switched off first.
- R8: At least one ALU is always powered: `gate_off` never has all bits set.
- R9: `gate_off` changes only at a window-closing edge. Changes on `leak_code` during the window have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ready_cnt | input | 6 | Ready-to-issue instruction count for this cycle |
| thr_wr_en | input | 1 | Threshold write strobe |
| thr_wr_idx | input | 2 | Threshold index to write (0 to 2 valid) |
| thr_wr_data | input | 10 | New threshold value |
| leak_code | input | 12 | Four 3-bit leakage-sensor codes, ALU i in bits [3i+2:3i] |
| gate_off | output | 4 | Per-ALU gate mask, 1 means the ALU is powered off |
| win_sum | output | 10 | Window total registered at the last boundary |

## Verification
Constant ready counts from 0 to 7 separate correct clipping from passing the raw count through. A pattern that puts large counts only on off-stride cycles shows whether non-sample cycles leak into the total. Window totals built to land exactly on and one below each threshold tell a meets-or-exceeds compare apart from a strict one. Sweeps of leakage codes, covering distinct codes, all-equal codes and codes that change mid-window, exercise the ranking, the index tie-break and mask holding, with programmed thresholds and a reset mid-run checked as well.

// File: rtl/alu_gate_ctrl.sv
module alu_gate_ctrl #(
  parameter int N_ALU    = 4,
  parameter int ISSUE_W  = 4,
  parameter int RDY_W    = 6,
  parameter int LEAK_W   = 3,
  parameter int STRIDE   = 4,
  parameter int WINDOW   = 512,
  parameter int THR_BASE = 33,
  parameter int THR_STEP = 100,
  localparam int SAMPLES = WINDOW / STRIDE,
  localparam int MAXSUM  = SAMPLES * ISSUE_W,
  localparam int SUM_W   = $clog2(MAXSUM + 1),
  localparam int IDX_W   = $clog2(N_ALU),
  localparam int CNT_W   = $clog2(N_ALU + 1),
  localparam int CYC_W   = $clog2(WINDOW)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [RDY_W-1:0]          ready_cnt,
  input  logic                      thr_wr_en,
  input  logic [IDX_W-1:0]          thr_wr_idx,
  input  logic [SUM_W-1:0]          thr_wr_data,
  input  logic [N_ALU*LEAK_W-1:0]   leak_code,
  output logic [N_ALU-1:0]          gate_off,
  output logic [SUM_W-1:0]          win_sum
);

  logic [CYC_W-1:0]              cyc;
  logic [SUM_W-1:0]              acc;
  logic [N_ALU-2:0][SUM_W-1:0]   thr;
  logic [SUM_W-1:0]              rdy_clip;
  logic [SUM_W-1:0]              total;
  logic [CNT_W-1:0]              n_met;
  logic [CNT_W-1:0]              n_gate;
  logic [N_ALU-1:0]              nxt_mask;
  logic                          sample;
  logic                          win_end;

  assign sample   = (cyc % CYC_W'(STRIDE)) == CYC_W'(STRIDE - 1);
  assign win_end  = cyc == CYC_W'(WINDOW - 1);
  assign rdy_clip = (ready_cnt > RDY_W'(ISSUE_W)) ? SUM_W'(ISSUE_W) : SUM_W'(ready_cnt);
  assign total    = acc + (sample ? rdy_clip : '0);

  always_comb begin
    n_met = '0;
    for (int t = 0; t < N_ALU - 1; t++)
      if (total >= thr[t]) n_met = n_met + CNT_W'(1);
  end

  assign n_gate = CNT_W'(N_ALU - 1) - n_met;

  for (genvar i = 0; i < N_ALU; i++) begin : g_rank
    logic [CNT_W-1:0] rank;
    always_comb begin
      rank = '0;
      for (int j = 0; j < N_ALU; j++)
        if (j != i) begin
          if ((leak_code[j*LEAK_W +: LEAK_W] > leak_code[i*LEAK_W +: LEAK_W]) ||
              ((leak_code[j*LEAK_W +: LEAK_W] == leak_code[i*LEAK_W +: LEAK_W]) && (j > i)))
            rank = rank + CNT_W'(1);
        end
    end
    assign nxt_mask[i] = rank < n_gate;
  end

  for (genvar t = 0; t < N_ALU - 1; t++) begin : g_thr
    always_ff @(posedge clk) begin
      if (rst)
        thr[t] <= SUM_W'(THR_BASE + (t + 1) * THR_STEP);
      else if (thr_wr_en && (thr_wr_idx == IDX_W'(t)))
        thr[t] <= thr_wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc      <= '0;
      acc      <= '0;
      gate_off <= '0;
      win_sum  <= '0;
    end else begin
      cyc <= win_end ? '0 : cyc + CYC_W'(1);
      acc <= win_end ? '0 : total;
      if (win_end) begin
        win_sum  <= total;
        gate_off <= nxt_mask;
      end
    end
  end

endmodule

// File: rtl/alu_gate_ctrl_chk.sv
module alu_gate_ctrl_chk #(
  parameter int N_ALU  = 4,
  parameter int LEAK_W = 3,
  parameter int SUM_W  = 10,
  parameter int MAXSUM = 512
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    win_end,
  input logic [N_ALU*LEAK_W-1:0] leak_code,
  input logic [N_ALU-1:0]        gate_off,
  input logic [SUM_W-1:0]        win_sum
);

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (gate_off == '0 && win_sum == '0)); // R1

  AST_SUM_RANGE: assert property (@(posedge clk) disable iff (rst) win_sum <= SUM_W'(MAXSUM)); // R3

  AST_ONE_ALIVE: assert property (@(posedge clk) disable iff (rst) !(&gate_off)); // R8

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(win_end) |-> ($stable(gate_off) && $stable(win_sum))); // R9

  for (genvar i = 0; i < N_ALU; i++) begin : g_i
    for (genvar j = 0; j < N_ALU; j++) begin : g_j
      if (i != j) begin : g_pair
        AST_LEAK_ORDER: assert property (@(posedge clk) disable iff (rst)
          ($past(win_end) && gate_off[i] && !gate_off[j]) |->
          (($past(leak_code[i*LEAK_W +: LEAK_W]) > $past(leak_code[j*LEAK_W +: LEAK_W])) ||
           (($past(leak_code[i*LEAK_W +: LEAK_W]) == $past(leak_code[j*LEAK_W +: LEAK_W])) && (i > j)))); // R7
      end
    end
  end

endmodule

bind alu_gate_ctrl alu_gate_ctrl_chk #(
  .N_ALU(N_ALU), .LEAK_W(LEAK_W), .SUM_W(SUM_W), .MAXSUM(MAXSUM)
) u_chk (
  .clk(clk), .rst(rst), .win_end(win_end), .leak_code(leak_code),
  .gate_off(gate_off), .win_sum(win_sum)
);

// File: tb/alu_gate_ctrl_bench.sv
module alu_gate_ctrl_bench;

  logic        clk = 0;
  logic        rst = 1;
  logic [5:0]  ready_cnt = 0;
  logic        thr_wr_en = 0;
  logic [1:0]  thr_wr_idx = 0;
  logic [9:0]  thr_wr_data = 0;
  logic [11:0] leak_code = 0;
  logic [3:0]  gate_off;
  logic [9:0]  win_sum;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int thr_m [3];
  logic [3:0] prev_gate;
  int prev_sum;

  always #5 clk = ~clk;

  alu_gate_ctrl u_alu_gate_ctrl (
    .clk(clk), .rst(rst), .ready_cnt(ready_cnt), .thr_wr_en(thr_wr_en),
    .thr_wr_idx(thr_wr_idx), .thr_wr_data(thr_wr_data), .leak_code(leak_code),
    .gate_off(gate_off), .win_sum(win_sum)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] model_mask(input int s, input logic [11:0] lk);
    int met = 0;
    int g;
    logic [3:0] m = 0;
    for (int t = 0; t < 3; t++) if (s >= thr_m[t]) met++;
    g = 3 - met;
    for (int i = 0; i < 4; i++) begin
      int r = 0;
      for (int j = 0; j < 4; j++)
        if (j != i && ((lk[j*3 +: 3] > lk[i*3 +: 3]) || (lk[j*3 +: 3] == lk[i*3 +: 3] && j > i))) r++;
      m[i] = r < g;
    end
    return m;
  endfunction

  function automatic int pat(input int mode, input int p, input int k);
    int v;
    case (mode)
      0: return p;
      1: return (k * 7 + p) % 64;
      2: return (k % 4 == 3) ? 0 : 63;
      default: begin
        if (k % 4 != 3) return 5 + (k % 50);
        v = p - 4 * (k / 4);
        if (v < 0) v = 0;
        if (v > 4) v = 4 + (k % 3);
        return v;
      end
    endcase
  endfunction

  task automatic run_window(input int mode, input int p, input logic [11:0] lk_end,
                            input logic [11:0] lk_mid, input bit do_thr,
                            input int n0, input int n1, input int n2);
    int exp_sum = 0;
    int rv;
    logic [3:0] exp_mask;
    for (int k = 0; k < 512; k++) begin
      if (k > 0) @(negedge clk);
      rv = pat(mode, p, k);
      ready_cnt = rv[5:0];
      leak_code = (k == 511) ? lk_end : lk_mid + 12'(k * 37);
      thr_wr_en = 0;
      if (do_thr && k < 4) begin
        thr_wr_en = 1;
        thr_wr_idx = 2'(k);
        thr_wr_data = (k == 0) ? 10'(n0) : (k == 1) ? 10'(n1) : (k == 2) ? 10'(n2) : 10'd0;
        if (k == 0) thr_m[0] = n0;
        if (k == 1) thr_m[1] = n1;
        if (k == 2) thr_m[2] = n2;
      end
      if (k % 4 == 3) exp_sum += (rv > 4) ? 4 : rv;
      if (k == 200) begin
        check(gate_off == prev_gate, "R9 mask held mid-window", gate_off, prev_gate);
        check(win_sum == 10'(prev_sum), "R4 sum held mid-window", win_sum, prev_sum);
      end
    end
    @(negedge clk);
    thr_wr_en = 0;
    exp_mask = model_mask(exp_sum, lk_end);
    check(win_sum == 10'(exp_sum), "R3 R2 window total", win_sum, exp_sum);
    check(gate_off == exp_mask, "R5 R7 gate mask", gate_off, exp_mask);
    check(!(&gate_off), "R8 one ALU on", gate_off, 0);
    prev_gate = gate_off;
    prev_sum = int'(win_sum);
  endtask

  task automatic reset_defaults();
    thr_m[0] = 133; thr_m[1] = 233; thr_m[2] = 333;
    prev_gate = 0; prev_sum = 0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] lk;
    logic [11:0] distinct;
    int edges [7];
    int seed;
    reset_defaults();
    distinct = {3'd1, 3'd7, 3'd2, 3'd5};
    repeat (3) @(negedge clk);
    check(gate_off == 4'b0000, "R1 reset mask", gate_off, 0);
    check(win_sum == 10'd0, "R1 reset sum", win_sum, 0);
    rst = 0;

    // R2: constant counts 0..7, clipped at 4
    for (int v = 0; v < 8; v++) run_window(0, v, distinct, 12'h5a5, 0, 0, 0, 0);
    // R3: counts only on off-stride cycles are ignored
    run_window(2, 0, distinct, 12'h123, 0, 0, 0, 0);
    // R5: totals on and just below each threshold, all-equal leakage for R7 tie-break
    edges = '{132, 133, 232, 233, 332, 333, 512};
    foreach (edges[e]) run_window(3, edges[e], 12'o3333, 12'h777, 0, 0, 0, 0);
    foreach (edges[e]) run_window(3, edges[e], {3'd4, 3'd4, 3'd6, 3'd0}, 12'h0f0, 0, 0, 0, 0);
    // R6: program thresholds, index 3 write is junk and ignored
    run_window(3, 20, distinct, 12'h3c3, 1, 10, 20, 30);
    run_window(3, 9, {3'd0, 3'd0, 3'd0, 3'd0}, 12'h111, 0, 0, 0, 0);
    run_window(3, 30, distinct, 12'h222, 0, 0, 0, 0);
    run_window(1, 3, {3'd2, 3'd2, 3'd7, 3'd7}, 12'h999, 1, 300, 400, 500);
    // sweep of leakage codes and totals
    seed = 17;
    for (int w = 0; w < 40; w++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      lk = seed[19:8];
      if (w == 20) run_window(0, 0, lk, 12'h000, 1, 133, 233, 333);
      else run_window(3, (w * 61) % 513, lk, seed[11:0], 0, 0, 0, 0);
    end
    // R1: reset mid-run restores defaults
    repeat (100) @(negedge clk);
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    check(gate_off == 4'b0000, "R1 reset clears mask", gate_off, 0);
    check(win_sum == 10'd0, "R1 reset clears sum", win_sum, 0);
    rst = 0;
    reset_defaults();
    run_window(3, 133, distinct, 12'h0ab, 0, 0, 0, 0);
    run_window(3, 132, distinct, 12'h0cd, 0, 0, 0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule